// File: doc/BRIEF.md
# System Configuration Register Bank

This block is a word-addressed bank of 32-bit configuration and status words on a simple request/response slave port. The byte address of a request is divided by four to pick a word. Reads return the word one cycle later. Writes land on the clock edge of the request. At reset every word loads a fixed value. A clock-control word is filled from two peripheral-bus clock divisor parameters, each packed into a 3-bit code.

Some words are protected and silently keep their contents when written. These are the oscillator status word and the three memory remap words. A write to a remap word that would have changed it raises a one-cycle "remap unsupported" pulse. Accesses past the end of the bank change nothing, read as zero and raise an error flag. Every write is also classified on a small code output.

The access sequencer is a state machine with six states. ST_IDLE means no request in the previous cycle. ST_RD_OK is an in-range read. ST_RD_BAD is an out-of-range read. ST_WR_STORE is a plain store. ST_WR_PROT is a write to a protected word. ST_WR_BAD is an out-of-range write. From any state, the next state follows from the current request alone:
- no request leads to ST_IDLE;
- a read goes to ST_RD_OK or ST_RD_BAD, depending on the range;
- a write goes to ST_WR_BAD if out of range, else ST_WR_PROT if protected, else ST_WR_STORE.

Top module: `sysreg_bank`

## Requirements
- R1: The word index is the byte address shifted right by two; the two lowest address bits have no effect on which word is read or written.
- R2: A read request produces `bus_rvalid` high for exactly the next cycle, with the data on `bus_rdata` in that same cycle. `bus_rdata` is zero in any cycle without a read response.
- R3: After reset, word 38 holds 0x021A2358, word 39 holds 0x00000003, and every word other than 18, 38 and 39 holds zero.
- R4: After reset, word 18 holds the code of divisor 0 in bits [7:5] and the code of divisor 1 in bits [4:2]; all its other bits are zero.
- R5: The divisor code is the trailing-zero count of the divisor below 8 and that count plus one from 8 upward, so 1,2,4,8,16,32 give 0,1,2,4,5,6.
- R6: A write to an unprotected in-range word stores the data, is read back unchanged, and shows `bus_wclass` = 1 in the following cycle.
- R7: A write to word 39 leaves it unchanged and shows `bus_wclass` = 2 in the following cycle.
- R8: Writes to words 0, 2 and 4 leave them unchanged and show `bus_wclass` = 2. `remap_unsup` pulses in the following cycle only when the written data differs from the stored word.
- R9: A write with word index at or beyond the bank size changes no word and shows `bus_err` = 1 and `bus_wclass` = 3 in the following cycle.
- R10: A read with word index at or beyond the bank size returns zero with `bus_rvalid` = 1 and `bus_err` = 1 in the following cycle.
- R11: Elaboration fails unless each divisor parameter is a power of two from 1 to 32, defaulting to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| bus_rvalid | output | 1 | Read response strobe |
| bus_err | output | 1 | Out-of-range access seen in previous cycle |
| bus_wclass | output | 2 | Write class of previous cycle: 0 none, 1 store, 2 protected, 3 out of range |
| remap_unsup | output | 1 | Pulse on a changing write to a remap word |

## Verification
Three instances are built with the divisor pairs (2,2), (8,32) and (1,16). Reading their clock words separates the below-8 and from-8 branches of the code, as well as the end points 1 and 32. The stimulus mixes plain stores, including one made with nonzero low address bits, against writes to the status and remap words. A remap write with unchanged data is set beside one with new data, so that a pulse raised on every protected write is told apart from one raised only on a change. Out-of-range reads and writes probe the first index past the bank and a far index, alongside the last in-range word.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

    localparam int unsigned DATA_W = 32;

    // word indices whose behaviour differs from a plain store
    localparam int unsigned IX_ESRAM  = 0;
    localparam int unsigned IX_DDR    = 2;
    localparam int unsigned IX_REMAP  = 4;
    localparam int unsigned IX_CLKDIV = 18;
    localparam int unsigned IX_PLL_LO = 38;
    localparam int unsigned IX_PLL_ST = 39;

    localparam logic [DATA_W-1:0] PLL_LO_INIT = 32'h021A_2358;
    localparam logic [DATA_W-1:0] PLL_ST_INIT = 32'h0000_0003;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_OK    = 3'd1,
        ST_RD_BAD   = 3'd2,
        ST_WR_STORE = 3'd3,
        ST_WR_PROT  = 3'd4,
        ST_WR_BAD   = 3'd5
    } acc_state_t;

    typedef enum logic [1:0] {
        WC_NONE  = 2'd0,
        WC_STORE = 2'd1,
        WC_PROT  = 2'd2,
        WC_RANGE = 2'd3
    } wr_class_t;

    function automatic bit div_legal(input int unsigned d);
        return (d >= 1) && (d <= 32) && ((d & (d - 1)) == 0);
    endfunction

    // trailing zeros below 8, trailing zeros plus one from 8 upward
    function automatic logic [2:0] div_code(input int unsigned d);
        int unsigned tz;
        bit found;
        tz = 0;
        found = 1'b0;
        for (int b = 0; b < 6; b++) begin
            if (!found && d[b]) begin
                tz = b;
                found = 1'b1;
            end
        end
        return (d < 8) ? 3'(tz) : 3'(tz + 1);
    endfunction

    function automatic logic [DATA_W-1:0] reset_word(input int unsigned idx,
                                                     input int unsigned d0,
                                                     input int unsigned d1);
        logic [DATA_W-1:0] v;
        v = '0;
        if (idx == IX_PLL_LO) v = PLL_LO_INIT;
        else if (idx == IX_PLL_ST) v = PLL_ST_INIT;
        else if (idx == IX_CLKDIV) v = {24'd0, div_code(d0), div_code(d1), 2'b00};
        return v;
    endfunction

endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
    import sysreg_pkg::*;
#(
    parameter int unsigned NW = 64,
    parameter int unsigned AW = 10,
    localparam int unsigned IXW = AW - 2
) (
    input  logic [AW-1:0]  addr,
    output logic [IXW-1:0] idx,
    output logic           in_range,
    output logic           prot,
    output logic           remap_hit,
    output logic [NW-1:0]  sel
);

    assign idx       = addr[AW-1:2];
    assign in_range  = ({{(32-IXW){1'b0}}, idx} < 32'(NW));
    assign remap_hit = (idx == IXW'(IX_ESRAM)) || (idx == IXW'(IX_DDR)) ||
                       (idx == IXW'(IX_REMAP));
    assign prot      = in_range && (remap_hit || (idx == IXW'(IX_PLL_ST)));

    for (genvar i = 0; i < NW; i++) begin : g_sel
        assign sel[i] = (idx == IXW'(i));
    end

endmodule

// File: rtl/sysreg_store.sv
module sysreg_store
    import sysreg_pkg::*;
#(
    parameter int unsigned NW  = 64,
    parameter int unsigned DV0 = 2,
    parameter int unsigned DV1 = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_go,
    input  logic [NW-1:0]              sel,
    input  logic [DATA_W-1:0]          wdata,
    output logic [NW-1:0][DATA_W-1:0]  words
);

    for (genvar i = 0; i < NW; i++) begin : g_word
        localparam logic [DATA_W-1:0] RV = reset_word(i, DV0, DV1);
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n)                q <= RV;
            else if (wr_go && sel[i])  q <= wdata;
        end
        assign words[i] = q;
    end

endmodule

// File: rtl/sysreg_ctrl.sv
module sysreg_ctrl
    import sysreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic              hit_in_range,
    input  logic              hit_prot,
    input  logic              hit_remap,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cur_word,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              err,
    output logic [1:0]        wclass,
    output logic              remap_flag
);

    acc_state_t        st_q, st_d;
    logic [DATA_W-1:0] rdata_q;
    logic              remap_q;

    always_comb begin
        if (!req_valid)         st_d = ST_IDLE;
        else if (!req_we)       st_d = hit_in_range ? ST_RD_OK : ST_RD_BAD;
        else if (!hit_in_range) st_d = ST_WR_BAD;
        else if (hit_prot)      st_d = ST_WR_PROT;
        else                    st_d = ST_WR_STORE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            rdata_q <= '0;
            remap_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            rdata_q <= (st_d == ST_RD_OK) ? cur_word : '0;
            remap_q <= (st_d == ST_WR_PROT) && hit_remap && (wdata != cur_word);
        end
    end

    always_comb begin
        rvalid = 1'b0;
        err    = 1'b0;
        wclass = WC_NONE;
        unique case (st_q)
            ST_IDLE:     ;
            ST_RD_OK:    rvalid = 1'b1;
            ST_RD_BAD: begin
                rvalid = 1'b1;
                err    = 1'b1;
            end
            ST_WR_STORE: wclass = WC_STORE;
            ST_WR_PROT:  wclass = WC_PROT;
            ST_WR_BAD: begin
                err    = 1'b1;
                wclass = WC_RANGE;
            end
            default:     ;
        endcase
    end

    assign rdata      = rdata_q;
    assign remap_flag = remap_q;

endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
    import sysreg_pkg::*;
#(
    parameter int unsigned PCLK0_DIV = 2,
    parameter int unsigned PCLK1_DIV = 2,
    parameter int unsigned NWORDS    = 64,
    parameter int unsigned ADDR_W    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              bus_err,
    output logic [1:0]        bus_wclass,
    output logic              remap_unsup
);

    localparam int unsigned IXW = ADDR_W - 2;
    localparam int unsigned IW  = $clog2(NWORDS);

    // R11: illegal configurations stop elaboration
    if (!div_legal(PCLK0_DIV) || !div_legal(PCLK1_DIV)) begin : g_bad_div
        $error("divisor parameters must be powers of two from 1 to 32");
    end
    if (NWORDS <= IX_PLL_ST || IW > IXW) begin : g_bad_size
        $error("bank size does not fit the fixed word map or the address");
    end

    logic [IXW-1:0]                idx;
    logic                          in_range, prot, remap_hit, wr_go;
    logic [NWORDS-1:0]             sel;
    logic [NWORDS-1:0][DATA_W-1:0] words;
    logic [DATA_W-1:0]             cur_word;

    sysreg_decode #(.NW(NWORDS), .AW(ADDR_W)) u_dec (
        .addr      (bus_addr),
        .idx       (idx),
        .in_range  (in_range),
        .prot      (prot),
        .remap_hit (remap_hit),
        .sel       (sel)
    );

    assign wr_go    = bus_valid && bus_we && in_range && !prot;
    assign cur_word = words[idx[IW-1:0]];

    sysreg_store #(.NW(NWORDS), .DV0(PCLK0_DIV), .DV1(PCLK1_DIV)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_go (wr_go),
        .sel   (sel),
        .wdata (bus_wdata),
        .words (words)
    );

    sysreg_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (bus_valid),
        .req_we       (bus_we),
        .hit_in_range (in_range),
        .hit_prot     (prot),
        .hit_remap    (remap_hit),
        .wdata        (bus_wdata),
        .cur_word     (cur_word),
        .rdata        (bus_rdata),
        .rvalid       (bus_rvalid),
        .err          (bus_err),
        .wclass       (bus_wclass),
        .remap_flag   (remap_unsup)
    );

endmodule

// File: rtl/sysreg_bank_chk.sv
module sysreg_bank_chk
    import sysreg_pkg::*;
#(
    parameter int unsigned NW = 64,
    parameter int unsigned AW = 10
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_valid,
    input logic                      bus_we,
    input logic [AW-1:0]             bus_addr,
    input logic [31:0]               bus_rdata,
    input logic                      bus_rvalid,
    input logic                      bus_err,
    input logic [1:0]                bus_wclass,
    input logic                      remap_unsup,
    input logic [NW-1:0][DATA_W-1:0] words
);

    logic oor;
    assign oor = (32'(bus_addr) >> 2) >= 32'(NW);

    p_read_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_we) |=> bus_rvalid);

    p_no_stray_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_we) |=> (!bus_rvalid && bus_rdata == '0));

    p_pll_st_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        words[IX_PLL_ST] == PLL_ST_INIT);

    p_remap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(words[IX_ESRAM]) && $stable(words[IX_DDR]) && $stable(words[IX_REMAP]));

    p_remap_is_prot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        remap_unsup |-> bus_wclass == 2'd2);

    p_oor_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_we && oor) |=> ($stable(words) && bus_err && bus_wclass == 2'd3));

    p_oor_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_we && oor) |=> (bus_rdata == '0 && bus_err && bus_rvalid));

endmodule

bind sysreg_bank sysreg_bank_chk #(.NW(NWORDS), .AW(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .bus_rvalid  (bus_rvalid),
    .bus_err     (bus_err),
    .bus_wclass  (bus_wclass),
    .remap_unsup (remap_unsup),
    .words       (words)
);

// File: tb/sim_sysreg_bank.sv
`timescale 1ns/1ps
module sim_sysreg_bank;

    localparam int AW = 10;
    localparam int NW = 64;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          valid = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;

    logic [31:0] rd   [3];
    logic        rv   [3];
    logic        er   [3];
    logic [1:0]  wc   [3];
    logic        rm   [3];

    sysreg_bank u0 (.clk(clk), .rst_n(rst_n), .bus_valid(valid), .bus_we(we),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd[0]), .bus_rvalid(rv[0]),
        .bus_err(er[0]), .bus_wclass(wc[0]), .remap_unsup(rm[0]));
    sysreg_bank #(.PCLK0_DIV(8), .PCLK1_DIV(32)) u1 (.clk(clk), .rst_n(rst_n),
        .bus_valid(valid), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rd[1]), .bus_rvalid(rv[1]), .bus_err(er[1]), .bus_wclass(wc[1]),
        .remap_unsup(rm[1]));
    sysreg_bank #(.PCLK0_DIV(1), .PCLK1_DIV(16)) u2 (.clk(clk), .rst_n(rst_n),
        .bus_valid(valid), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rd[2]), .bus_rvalid(rv[2]), .bus_err(er[2]), .bus_wclass(wc[2]),
        .remap_unsup(rm[2]));

    // R11: the three instances above use legal divisor pairs only
    int d0s [3] = '{2, 8, 1};
    int d1s [3] = '{2, 32, 16};

    typedef struct {
        bit          rv;
        bit          er;
        logic [1:0]  wc;
        bit          rm;
        logic [31:0] r [3];
        string       tag;
    } exp_t;

    exp_t        q [$];
    logic [31:0] mdl [3][NW];
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;
    logic        launched = 1'b0;

    // R5 reference table
    function automatic logic [2:0] enc_ref(input int d);
        case (d)
            1:  return 3'd0;
            2:  return 3'd1;
            4:  return 3'd2;
            8:  return 3'd4;
            16: return 3'd5;
            32: return 3'd6;
            default: return 3'd7;
        endcase
    endfunction

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic acc(input bit w, input int idx, input logic [1:0] lo,
                       input logic [31:0] d, input string tag);
        exp_t e;
        bit inr, prot, rmw;
        inr  = idx < NW;
        rmw  = (idx == 0) || (idx == 2) || (idx == 4);
        prot = rmw || (idx == 39);
        e.rv = !w;
        e.er = !inr;
        e.wc = 2'd0;
        e.rm = 1'b0;
        e.tag = tag;
        for (int k = 0; k < 3; k++) e.r[k] = '0;
        if (!w) begin
            if (inr) for (int k = 0; k < 3; k++) e.r[k] = mdl[k][idx];
        end else if (!inr) begin
            e.wc = 2'd3;
        end else if (prot) begin
            e.wc = 2'd2;
            e.rm = rmw && (d != mdl[0][idx]);
        end else begin
            e.wc = 2'd1;
            for (int k = 0; k < 3; k++) mdl[k][idx] = d;
        end
        @(negedge clk);
        valid = 1'b1;
        we    = w;
        addr  = AW'((idx << 2) | int'(lo));
        wdata = d;
        q.push_back(e);
    endtask

    always @(posedge clk) launched <= valid;

    always @(negedge clk) begin
        if (launched) begin
            if (q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL scoreboard: actual response expected none");
            end else begin
                exp_t e;
                e = q.pop_front();
                cmp({e.tag, " rvalid"}, 32'(rv[0]), 32'(e.rv));
                cmp({e.tag, " err"}, 32'(er[0]), 32'(e.er));
                cmp({e.tag, " wclass"}, 32'(wc[0]), 32'(e.wc));
                cmp({e.tag, " remap"}, 32'(rm[0]), 32'(e.rm));
                for (int k = 0; k < 3; k++)
                    cmp($sformatf("%s rdata u%0d", e.tag, k), rd[k], e.r[k]);
            end
        end
    end

    initial begin
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < NW; i++) mdl[k][i] = '0;
            mdl[k][38] = 32'h021A_2358;
            mdl[k][39] = 32'h0000_0003;
            mdl[k][18] = {24'd0, enc_ref(d0s[k]), enc_ref(d1s[k]), 2'b00};
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R2 reset rvalid", 32'(rv[0]), 32'd0);
        cmp("R2 reset rdata", rd[0], 32'd0);
        cmp("R9 reset err", 32'(er[0]), 32'd0);

        acc(0, 38, 2'b00, 0, "R3 pll low word");
        acc(0, 39, 2'b00, 0, "R3 pll status word");
        acc(0, 18, 2'b00, 0, "R4 R5 clock word");
        acc(0, 5, 2'b00, 0, "R3 other word zero");
        acc(0, 63, 2'b00, 0, "R3 last word zero");
        acc(1, 38, 2'b11, 32'hA5A5_0F0F, "R1 R6 store low bits set");
        acc(0, 38, 2'b10, 0, "R1 R6 readback");
        acc(1, 16, 2'b00, 32'h1234_5678, "R6 plain store");
        acc(0, 16, 2'b01, 0, "R6 plain readback");
        acc(1, 39, 2'b00, 32'hFFFF_FFFF, "R7 status write");
        acc(0, 39, 2'b00, 0, "R7 status kept");
        acc(1, 0, 2'b00, 32'h0, "R8 same value no pulse");
        acc(1, 2, 2'b00, 32'hDEAD_BEEF, "R8 changing value pulse");
        acc(1, 4, 2'b00, 32'h1, "R8 remap base write");
        acc(0, 2, 2'b00, 0, "R8 remap word kept");
        acc(0, 4, 2'b00, 0, "R8 remap base kept");
        acc(1, 63, 2'b00, 32'h0BAD_F00D, "R6 last word store");
        acc(1, 64, 2'b00, 32'hCAFE_0001, "R9 first out of range write");
        acc(1, 255, 2'b00, 32'hCAFE_0002, "R9 far out of range write");
        acc(0, 63, 2'b00, 0, "R9 last word unchanged");
        acc(0, 64, 2'b00, 0, "R10 first out of range read");
        acc(0, 200, 2'b11, 0, "R10 far out of range read");
        acc(0, 18, 2'b00, 0, "R4 clock word again");
        @(negedge clk);
        valid = 1'b0;
        we    = 1'b0;
        repeat (3) @(negedge clk);
        cmp("R2 idle rvalid", 32'(rv[0]), 32'd0);
        if (q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule